// File: doc/BRIEF.md
# Control Unit Selection Chain

This block decides which of several control units on a shared chain answers a device address issued by the channel. The units sit in a fixed physical order. Each one has an inclusive address window, given as a lower and an upper bound, and a flag that sets its claim direction. A unit whose flag is clear (high priority) may claim while selection travels away from the channel. A unit whose flag is set (low priority) may claim only while selection travels back toward the channel. The unit at the far end is visited once, at the turn-around point, and claims there whatever its flag.

The walk visits one unit per clock cycle. When a unit claims, the block pulses `done` and reports that unit's index and the position along the path where the claim happened. That position is also the unit's effective priority rank: rank u+1 for a high unit at index u, and 2N-1-u for a low one. If selection returns to the channel unclaimed, `done` pulses with `noResp` set.

Top module: `cu_chain_sel`

## Requirements
- R1: A unit claims an 8-bit address only if lower bound <= address <= upper bound, both ends included; an address outside every window is not claimed.
- R2: Outbound, units are visited in order 0, 1, ..., N-1, and a unit whose `lowPri` bit (bit u for unit u) is 0 claims an in-range address.
- R3: Inbound, units N-2 down to 0 are visited, and only a unit whose `lowPri` bit is 1 claims there.
- R4: Unit N-1 claims an in-range address at path position N, whatever its `lowPri` bit.
- R5: If no unit claims, `done` pulses with `noResp`=1, `unitIdx`=0 and `pathPos`=0.
- R6: `pathPos` on a claim is u+1 for a high unit u and 2N-1-u for a low unit u.
- R7: When windows overlap, the unit reached first along the path wins.
- R8: `busy` rises on the edge that accepts `reqValid`, and `done` is a one-cycle pulse exactly `pathPos` edges later for a claim (2N-1 edges for no response); `busy` is low while `done` is high.
- R9: `reqValid` while `busy` is high is ignored and does not change the result of the walk in progress.
- R10: After reset, `busy`, `done`, `noResp`, `unitIdx` and `pathPos` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rangeLo | input | NUM_UNITS*ADDR_W | Lower window bounds, unit u in bits [u*ADDR_W +: ADDR_W] |
| rangeHi | input | NUM_UNITS*ADDR_W | Upper window bounds, same packing |
| lowPri | input | NUM_UNITS | Bit u set: unit u claims on the return pass only |
| reqValid | input | 1 | Start a selection when idle |
| reqAddr | input | ADDR_W | Device address to select |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| noResp | output | 1 | Last walk found no unit |
| unitIdx | output | IDX_W | Index of the claiming unit |
| pathPos | output | STEP_W | Path position (priority rank) of the claim |

## Verification
The assertions take for granted that the window bounds and priority flags stay unchanged from the accepting edge until `done`, since the walk reads them live and the claim checks compare against them at completion. The stimulus changes the configuration only on a falling edge while the block is idle, before raising `reqValid`, and never during a walk. A second `reqValid` during a walk is allowed and is exercised to show it is ignored.

// File: rtl/cu_sel_pkg.sv
package cu_sel_pkg;
  typedef struct packed {
    logic start;
    logic advance;
    logic finishHit;
    logic finishMiss;
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } selState_t;
endpackage

// File: rtl/cu_range_match.sv
module cu_range_match #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              match
);
  assign match = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/cu_sel_datapath.sv
module cu_sel_datapath
  import cu_sel_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 2,
  parameter int STEP_W    = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 ctl,
  input  logic [NUM_UNITS*ADDR_W-1:0] rangeLo,
  input  logic [NUM_UNITS*ADDR_W-1:0] rangeHi,
  input  logic [NUM_UNITS-1:0]        lowPri,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic                        hit,
  output logic                        lastStep,
  output logic                        done,
  output logic                        noResp,
  output logic [IDX_W-1:0]            unitIdx,
  output logic [STEP_W-1:0]           pathPos
);
  localparam int LAST_STEP = 2 * NUM_UNITS - 2;
  localparam int LAST_UNIT = NUM_UNITS - 1;

  logic [ADDR_W-1:0]    addrQ;
  logic [STEP_W-1:0]    stepQ;
  logic [NUM_UNITS-1:0] inRange;
  logic                 outbound;
  logic [STEP_W-1:0]    visitStep;
  logic [IDX_W-1:0]     visitIdx;
  logic                 isLastUnit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cu_range_match #(.ADDR_W(ADDR_W)) matchI (
      .addr  (addrQ),
      .lo    (rangeLo[u*ADDR_W +: ADDR_W]),
      .hi    (rangeHi[u*ADDR_W +: ADDR_W]),
      .match (inRange[u])
    );
  end

  always_comb begin
    outbound   = (stepQ < STEP_W'(NUM_UNITS));
    visitStep  = outbound ? stepQ : (STEP_W'(LAST_STEP) - stepQ);
    visitIdx   = visitStep[IDX_W-1:0];
    isLastUnit = (visitIdx == IDX_W'(LAST_UNIT));
    if (outbound) begin
      hit = inRange[visitIdx] && (!lowPri[visitIdx] || isLastUnit);
    end else begin
      hit = inRange[visitIdx] && lowPri[visitIdx];
    end
    lastStep = (stepQ == STEP_W'(LAST_STEP));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      stepQ   <= '0;
      done    <= 1'b0;
      noResp  <= 1'b0;
      unitIdx <= '0;
      pathPos <= '0;
    end else begin
      done <= ctl.finishHit | ctl.finishMiss;
      if (ctl.start) begin
        addrQ   <= reqAddr;
        stepQ   <= '0;
        noResp  <= 1'b0;
        unitIdx <= '0;
        pathPos <= '0;
      end else if (ctl.advance) begin
        stepQ <= stepQ + STEP_W'(1);
      end
      if (ctl.finishHit) begin
        unitIdx <= visitIdx;
        pathPos <= stepQ + STEP_W'(1);
        noResp  <= 1'b0;
      end else if (ctl.finishMiss) begin
        unitIdx <= '0;
        pathPos <= '0;
        noResp  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cu_sel_control.sv
module cu_sel_control
  import cu_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        lastStep,
  output ctlStrobes_t ctl,
  output logic        busy
);
  selState_t stateQ, stateD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.start = 1'b1;
          stateD    = ST_WALK;
        end
      end
      ST_WALK: begin
        if (hit) begin
          ctl.finishHit = 1'b1;
          stateD        = ST_IDLE;
        end else if (lastStep) begin
          ctl.finishMiss = 1'b1;
          stateD         = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_WALK);
endmodule

// File: rtl/cu_chain_sel.sv
module cu_chain_sel
  import cu_sel_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int STEP_W   = $clog2(2 * NUM_UNITS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_UNITS*ADDR_W-1:0] rangeLo,
  input  logic [NUM_UNITS*ADDR_W-1:0] rangeHi,
  input  logic [NUM_UNITS-1:0]        lowPri,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic                        busy,
  output logic                        done,
  output logic                        noResp,
  output logic [IDX_W-1:0]            unitIdx,
  output logic [STEP_W-1:0]           pathPos
);
  ctlStrobes_t ctl;
  logic        hit;
  logic        lastStep;

  cu_sel_control ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .hit      (hit),
    .lastStep (lastStep),
    .ctl      (ctl),
    .busy     (busy)
  );

  cu_sel_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .STEP_W    (STEP_W)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rangeLo  (rangeLo),
    .rangeHi  (rangeHi),
    .lowPri   (lowPri),
    .reqAddr  (reqAddr),
    .hit      (hit),
    .lastStep (lastStep),
    .done     (done),
    .noResp   (noResp),
    .unitIdx  (unitIdx),
    .pathPos  (pathPos)
  );
endmodule

// File: rtl/cu_chain_sel_chk.sv
module cu_chain_sel_chk #(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 2,
  parameter int STEP_W    = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_UNITS*ADDR_W-1:0] rangeLo,
  input logic [NUM_UNITS*ADDR_W-1:0] rangeHi,
  input logic [NUM_UNITS-1:0]        lowPri,
  input logic                        reqValid,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic                        busy,
  input logic                        done,
  input logic                        noResp,
  input logic [IDX_W-1:0]            unitIdx,
  input logic [STEP_W-1:0]           pathPos
);
  localparam int MISS_EDGES = 2 * NUM_UNITS - 1;

  logic [ADDR_W-1:0] addrSeen;
  logic [STEP_W:0]   edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSeen <= '0;
      edgeCnt  <= '0;
    end else if (reqValid && !busy) begin
      addrSeen <= reqAddr;
      edgeCnt  <= '0;
    end else if (busy) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  function automatic logic [STEP_W-1:0] rankOf(input logic [IDX_W-1:0] u,
                                               input logic [NUM_UNITS-1:0] fl);
    if (fl[u] && (int'(u) != NUM_UNITS - 1))
      return STEP_W'(2 * NUM_UNITS - 1 - int'(u));
    return STEP_W'(int'(u) + 1);
  endfunction

  AST_CLAIM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noResp) |-> (addrSeen >= rangeLo[unitIdx*ADDR_W +: ADDR_W]) &&
                          (addrSeen <= rangeHi[unitIdx*ADDR_W +: ADDR_W])); // R1

  AST_RANK_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noResp) |-> (pathPos == rankOf(unitIdx, lowPri))); // R6

  AST_MISS_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done && noResp) |-> (unitIdx == '0) && (pathPos == '0)); // R5

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noResp) |-> (edgeCnt == (STEP_W+1)'(pathPos))); // R8

  AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (done && noResp) |-> (edgeCnt == (STEP_W+1)'(MISS_EDGES))); // R5

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
endmodule

bind cu_chain_sel cu_chain_sel_chk #(
  .NUM_UNITS (NUM_UNITS),
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .STEP_W    (STEP_W)
) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .rangeLo  (rangeLo),
  .rangeHi  (rangeHi),
  .lowPri   (lowPri),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .busy     (busy),
  .done     (done),
  .noResp   (noResp),
  .unitIdx  (unitIdx),
  .pathPos  (pathPos)
);

// File: tb/cu_chain_sel_tb.sv
module cu_chain_sel_tb_top;
  localparam int N = 4;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N*AW-1:0] rangeLo;
  logic [N*AW-1:0] rangeHi;
  logic [N-1:0]    lowPri = '0;
  logic            reqValid = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic            busy, done, noResp;
  logic [1:0]      unitIdx;
  logic [2:0]      pathPos;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  cu_chain_sel #(.NUM_UNITS(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .rangeLo(rangeLo), .rangeHi(rangeHi),
    .lowPri(lowPri), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .done(done), .noResp(noResp),
    .unitIdx(unitIdx), .pathPos(pathPos)
  );

  // Windows: unit0 20-2F, unit1 40-7F, unit2 50-5F, unit3 80-8F
  initial begin
    rangeLo = {8'h80, 8'h50, 8'h40, 8'h20};
    rangeHi = {8'h8F, 8'h5F, 8'h7F, 8'h2F};
  end

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] flags;
    logic [7:0] addr;
    logic       miss;
    logic [1:0] unit;
    logic [2:0] pos;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 4'b0000, 8'h25, 1'b0, 2'd0, 3'd1},  // R2 first unit high
    '{4'd7, 4'b0000, 8'h55, 1'b0, 2'd1, 3'd2},  // R7 overlap, unit1 first
    '{4'd3, 4'b1111, 8'h55, 1'b0, 2'd2, 3'd5},  // R3 return pass
    '{4'd6, 4'b1111, 8'h25, 1'b0, 2'd0, 3'd7},  // R6 rank 2N-1
    '{4'd4, 4'b1111, 8'h85, 1'b0, 2'd3, 3'd4},  // R4 last unit
    '{4'd5, 4'b0000, 8'h30, 1'b1, 2'd0, 3'd0},  // R5 gap
    '{4'd2, 4'b0101, 8'h55, 1'b0, 2'd1, 3'd2},  // R2 mixed flags
    '{4'd7, 4'b0010, 8'h55, 1'b0, 2'd2, 3'd3},  // R7 unit1 low, unit2 wins
    '{4'd1, 4'b0000, 8'h2F, 1'b0, 2'd0, 3'd1},  // R1 upper bound
    '{4'd1, 4'b0000, 8'h20, 1'b0, 2'd0, 3'd1},  // R1 lower bound
    '{4'd1, 4'b1111, 8'h1F, 1'b1, 2'd0, 3'd0},  // R1 below window
    '{4'd4, 4'b1000, 8'h8F, 1'b0, 2'd3, 3'd4},  // R4 low flag on last unit
    '{4'd3, 4'b0010, 8'h45, 1'b0, 2'd1, 3'd6},  // R3 claim on return
    '{4'd5, 4'b1111, 8'h90, 1'b1, 2'd0, 3'd0}   // R5 above all
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Issue a request and return the number of edges from acceptance to done.
  task automatic runSel(input logic [7:0] a, input int midAddr, output int edges);
    @(negedge clk);
    reqAddr  = a;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    edges = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (midAddr >= 0 && edges == 2) begin
        reqAddr  = midAddr[7:0];
        reqValid = 1'b1;  // R9: must be ignored while busy
      end else begin
        reqValid = 1'b0;
      end
      if (done) break;
    end
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "busy", int'(busy), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "noResp/unitIdx/pathPos", int'({noResp, unitIdx, pathPos}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "busy after release", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[v].req);
      @(negedge clk);
      lowPri = VECS[v].flags;
      runSel(VECS[v].addr, -1, edges);
      check(tag, $sformatf("vec%0d result {noResp,unit,pos}", v),
            int'({noResp, unitIdx, pathPos}),
            int'({VECS[v].miss, VECS[v].unit, VECS[v].pos}));
      // R8 latency: pathPos edges for a claim, 2N-1 for no response
      check("R8", $sformatf("vec%0d latency", v), edges,
            VECS[v].miss ? 2*N-1 : int'(VECS[v].pos));
    end

    // R9: second request during a walk is ignored
    @(negedge clk);
    lowPri = 4'b1111;
    runSel(8'h55, 8'h25, edges);
    check("R9", "result after busy request", int'({noResp, unitIdx, pathPos}),
          int'({1'b0, 2'd2, 3'd5}));
    @(negedge clk);
    check("R9", "idle after ignored request", int'(busy), 0);

    // R8 busy during walk and done pulse width
    @(negedge clk);
    lowPri = 4'b0000;
    reqAddr = 8'h85;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R8", "busy after accept", int'(busy), 1);
    repeat (4) @(negedge clk);
    check("R8", "done at 4 edges", int'(done), 1);
    @(negedge clk);
    check("R8", "done one cycle", int'(done), 0);
    check("R4", "held result", int'({unitIdx, pathPos}), int'({2'd3, 3'd4}));

    finishRun();
  end
endmodule